// File: doc/BRIEF.md
# Per-Pin Vector Timing Formatter

This block sits behind one tester pin and converts a stream of pattern vectors, one per tester cycle, into timed pin actions. Each vector names one of 31 programmable time sets and carries a pin symbol. The time set supplies the vector length in sub-cycle ticks, the tick positions of the driver-enable, data, return and driver-disable edges, the tick of the compare strobe, and one of four drive formats. The block counts ticks through the vector and, for every tick, produces a driver-enable, a drive level and a strobe request. When the strobe fires on a compare symbol, the comparator's three-way classification (low, high, midband) is checked against the expected state, and a pass/fail result is reported on the next tick.

A two-state controller governs vector flow. IDLE waits for a vector; the **start** transition (IDLE to RUN) takes place when `vec_valid` is high. In RUN, the tick counter advances. On the last tick of the vector, the **chain** transition (RUN to RUN) loads the next vector with no gap if one is offered, and the **drain** transition (RUN to IDLE) takes place otherwise. The time-set entry is copied into the controller when a vector is loaded, so that entry governs the whole vector. Table writes are checked for consistent edge ordering, and a write that breaks the rules is discarded.

Top module: `pin_vector_formatter`

## Requirements
- R1: After reset, `drv_en`, `drv_lvl`, `strobe_req`, `res_valid` and `cfg_err` are low, the controller is in IDLE, and every time-set entry holds the default: NR format, period 4, edges on=0, data=0, return=0, off=4, strobe=1.
- R2: A table write is stored only if all of the following hold: index < 31, period >= 2, on <= data <= return <= off <= period, and strobe < period. Otherwise the write is discarded. `cfg_err` is registered and, from the cycle after a write, shows 1 for a rejected write and 0 for an accepted one.
- R3: `vec_take` is high in a cycle exactly when `vec_valid` is high and the block is either in IDLE or on the last tick of its vector. The vector is loaded at that clock edge and its tick 0 is the next cycle. After the drain transition, all outputs are low.
- R4: For drive symbols (code 0 = drive 0, code 1 = drive 1), `drv_en` is high exactly on ticks t with on <= t < off. For compare symbols, `drv_en` stays low.
- R5: In format code 0 (non-return), `drv_lvl` equals the data bit throughout the enabled window.
- R6: In format code 1 (return-low), `drv_lvl` is the data bit for data <= t < return and low elsewhere in the window. In format code 2 (return-high), it is the data bit in that span and high elsewhere in the window.
- R7: In format code 3 (surround-by-complement), `drv_lvl` is the data bit for data <= t < return and its complement elsewhere in the window.
- R8: `strobe_req` is high for exactly the one tick t == strobe, and only for compare symbols (codes 2..7).
- R9: One cycle after the strobe, `res_valid` pulses with `res_fail`. Comparator codes are 0 = low, 1 = high, 2 = midband. Symbol code 2 (L) passes only on low and code 3 (H) only on high. Code 4 (X) always passes. Codes 5 (V) and 6 (E) fail only on midband. Code 7 (M) passes only on midband.
- R10: A write with format code 3 is rejected if its period is below 4, so that surround-by-complement vectors last at least twice the minimum period.
- R11: Consecutive vectors may use different time sets, and each vector follows the period, edges and format of its own entry.
- R12: A write that is rejected leaves the previous entry in place, and vectors that use that index keep following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Time-set table write strobe |
| cfg_idx | input | 5 | Table entry to write |
| cfg_fmt | input | 2 | Drive format code |
| cfg_per | input | 8 | Vector period in ticks |
| cfg_on | input | 8 | Driver enable tick |
| cfg_dat | input | 8 | Data edge tick |
| cfg_ret | input | 8 | Return edge tick |
| cfg_off | input | 8 | Driver disable tick |
| cfg_stb | input | 8 | Compare strobe tick |
| cfg_err | output | 1 | Last write was rejected |
| vec_valid | input | 1 | A vector is offered |
| vec_tset | input | 5 | Time-set index of the offered vector |
| vec_sym | input | 3 | Pin symbol code of the offered vector |
| vec_take | output | 1 | Offered vector is loaded at this edge |
| cmp_res | input | 2 | Comparator class: 0 low, 1 high, 2 midband |
| drv_en | output | 1 | Pin driver enable |
| drv_lvl | output | 1 | Driven level |
| strobe_req | output | 1 | Sample the comparator this tick |
| res_valid | output | 1 | Compare result valid |
| res_fail | output | 1 | Compare result failed |

## Verification
The assertions assume that `vec_valid`, `vec_tset` and `vec_sym` are steady for the whole cycle in which they are offered. They also assume that `cmp_res` is already settled in the tick where `strobe_req` is high, and that comparator code 3 never appears. The bench changes inputs only on falling edges. It presents the next vector only on the last tick of the current one, and it drives a fixed, legal comparator class for each vector. Every time set it uses places the strobe at least two ticks before the end of the period, so each result is seen inside its own vector.

// File: rtl/vtf_pkg.sv
package vtf_pkg;
    parameter int TICK_W = 8;

    typedef enum logic [1:0] {FMT_NR, FMT_RL, FMT_RH, FMT_SBC} fmt_e;
    typedef enum logic [2:0] {SYM_D0, SYM_D1, SYM_L, SYM_H,
                              SYM_X, SYM_V, SYM_E, SYM_M} sym_e;
    typedef enum logic [1:0] {CMP_LO, CMP_HI, CMP_MID, CMP_RSV} cmp_e;
    typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [TICK_W-1:0] per;
        logic [TICK_W-1:0] t_on;
        logic [TICK_W-1:0] t_dat;
        logic [TICK_W-1:0] t_ret;
        logic [TICK_W-1:0] t_off;
        logic [TICK_W-1:0] t_stb;
    } tset_t;
endpackage

// File: rtl/vtf_tset_table.sv
module vtf_tset_table
    import vtf_pkg::*;
#(
    parameter int N_TSET  = 31,
    parameter int IDX_W   = 5,
    parameter int MIN_PER = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tset_t             wr_ent,
    output logic              err_q,
    input  logic [IDX_W-1:0]  rd_idx,
    output tset_t             rd_ent
);
    localparam logic [TICK_W-1:0] MIN_T = TICK_W'(MIN_PER);
    localparam logic [TICK_W-1:0] SBC_T = TICK_W'(2 * MIN_PER);
    localparam logic [IDX_W-1:0]  LIM_I = IDX_W'(N_TSET);
    localparam tset_t DEF_ENT = '{fmt: FMT_NR, per: TICK_W'(4),
                                  t_on: '0, t_dat: '0, t_ret: '0,
                                  t_off: TICK_W'(4), t_stb: TICK_W'(1)};

    tset_t tbl_q [N_TSET];
    logic  wr_ok;

    always_comb begin
        wr_ok = (wr_idx < LIM_I)
              && (wr_ent.per >= MIN_T)
              && ((wr_ent.fmt != FMT_SBC) || (wr_ent.per >= SBC_T))
              && (wr_ent.t_on  <= wr_ent.t_dat)
              && (wr_ent.t_dat <= wr_ent.t_ret)
              && (wr_ent.t_ret <= wr_ent.t_off)
              && (wr_ent.t_off <= wr_ent.per)
              && (wr_ent.t_stb <  wr_ent.per);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TSET; i++) tbl_q[i] <= DEF_ENT;
            err_q <= 1'b0;
        end else if (wr_en) begin
            err_q <= !wr_ok;
            if (wr_ok) tbl_q[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = (rd_idx < LIM_I) ? tbl_q[rd_idx] : DEF_ENT;

    // R2
    bad_order_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_ent.t_on > wr_ent.t_dat)) |=> err_q);
    // R10
    sbc_short_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_ent.fmt == FMT_SBC) && (wr_ent.per < SBC_T)) |=> err_q);
endmodule

// File: rtl/vtf_edge_seq.sv
module vtf_edge_seq
    import vtf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_valid,
    input  tset_t       vec_ent,
    input  sym_e        vec_sym,
    output logic        vec_take,
    output logic        drv_en,
    output logic        drv_lvl,
    output logic        strobe_req,
    output sym_e        cur_sym
);
    seq_st_e           state_q, state_d;
    logic [TICK_W-1:0] cnt_q;
    tset_t             cur_q;
    sym_e              sym_q;
    logic              last_tick;
    logic              is_drv;
    logic              in_win;
    logic              in_dat;
    logic              dbit;
    logic              lvl;

    assign last_tick = (cnt_q == cur_q.per - TICK_W'(1));
    assign vec_take  = vec_valid && ((state_q == ST_IDLE) || last_tick);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (vec_valid) state_d = ST_RUN;
            ST_RUN:  if (last_tick && !vec_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
            sym_q   <= SYM_X;
        end else begin
            state_q <= state_d;
            if (vec_take) begin
                cnt_q <= '0;
                cur_q <= vec_ent;
                sym_q <= vec_sym;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + TICK_W'(1);
            end
        end
    end

    always_comb begin
        is_drv = (state_q == ST_RUN) && ((sym_q == SYM_D0) || (sym_q == SYM_D1));
        in_win = (cnt_q >= cur_q.t_on) && (cnt_q < cur_q.t_off);
        in_dat = (cnt_q >= cur_q.t_dat) && (cnt_q < cur_q.t_ret);
        dbit   = (sym_q == SYM_D1);
        unique case (cur_q.fmt)
            FMT_NR:  lvl = dbit;
            FMT_RL:  lvl = in_dat ? dbit : 1'b0;
            FMT_RH:  lvl = in_dat ? dbit : 1'b1;
            FMT_SBC: lvl = in_dat ? dbit : !dbit;
        endcase
        drv_en     = is_drv && in_win;
        drv_lvl    = drv_en && lvl;
        strobe_req = (state_q == ST_RUN) && !is_drv && (cnt_q == cur_q.t_stb);
    end

    assign cur_sym = sym_q;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q < cur_q.per));
    // R3
    take_mid_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !last_tick) |-> !vec_take);
    // R4
    cmp_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sym_q != SYM_D0) && (sym_q != SYM_D1)) |-> !drv_en);
    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req |-> (!drv_en && (state_q == ST_RUN)));
endmodule

// File: rtl/vtf_compare.sv
module vtf_compare
    import vtf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  sym_e sym,
    input  cmp_e cmp,
    output logic res_valid,
    output logic res_fail
);
    logic mid, fail_d;

    assign mid = (cmp == CMP_MID) || (cmp == CMP_RSV);

    always_comb begin
        unique case (sym)
            SYM_L:          fail_d = (cmp != CMP_LO);
            SYM_H:          fail_d = (cmp != CMP_HI);
            SYM_V, SYM_E:   fail_d = mid;
            SYM_M:          fail_d = !mid;
            default:        fail_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fail  <= 1'b0;
        end else begin
            res_valid <= stb;
            res_fail  <= stb && fail_d;
        end
    end

    // R9
    res_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(stb));
    // R9
    fail_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fail |-> res_valid);
endmodule

// File: rtl/pin_vector_formatter.sv
module pin_vector_formatter
    import vtf_pkg::*;
#(
    parameter int N_TSET  = 31,
    parameter int MIN_PER = 2,
    parameter int IDX_W   = $clog2(N_TSET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_fmt,
    input  logic [TICK_W-1:0] cfg_per,
    input  logic [TICK_W-1:0] cfg_on,
    input  logic [TICK_W-1:0] cfg_dat,
    input  logic [TICK_W-1:0] cfg_ret,
    input  logic [TICK_W-1:0] cfg_off,
    input  logic [TICK_W-1:0] cfg_stb,
    output logic              cfg_err,
    input  logic              vec_valid,
    input  logic [IDX_W-1:0]  vec_tset,
    input  logic [2:0]        vec_sym,
    output logic              vec_take,
    input  logic [1:0]        cmp_res,
    output logic              drv_en,
    output logic              drv_lvl,
    output logic              strobe_req,
    output logic              res_valid,
    output logic              res_fail
);
    tset_t wr_ent, rd_ent;
    sym_e  cur_sym;

    assign wr_ent = '{fmt: fmt_e'(cfg_fmt), per: cfg_per, t_on: cfg_on,
                      t_dat: cfg_dat, t_ret: cfg_ret, t_off: cfg_off,
                      t_stb: cfg_stb};

    vtf_tset_table #(.N_TSET(N_TSET), .IDX_W(IDX_W), .MIN_PER(MIN_PER)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_ent (wr_ent),
        .err_q  (cfg_err),
        .rd_idx (vec_tset),
        .rd_ent (rd_ent)
    );

    vtf_edge_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_valid  (vec_valid),
        .vec_ent    (rd_ent),
        .vec_sym    (sym_e'(vec_sym)),
        .vec_take   (vec_take),
        .drv_en     (drv_en),
        .drv_lvl    (drv_lvl),
        .strobe_req (strobe_req),
        .cur_sym    (cur_sym)
    );

    vtf_compare u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (strobe_req),
        .sym       (cur_sym),
        .cmp       (cmp_e'(cmp_res)),
        .res_valid (res_valid),
        .res_fail  (res_fail)
    );

    // R8
    strobe_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_req |-> !drv_en);
    // R4
    level_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_lvl |-> drv_en);
endmodule

// File: tb/tb_pin_vector_formatter.sv
module tb_pin_vector_formatter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_idx = '0;
    logic [1:0] cfg_fmt = '0;
    logic [7:0] cfg_per = '0, cfg_on = '0, cfg_dat = '0, cfg_ret = '0,
                cfg_off = '0, cfg_stb = '0;
    logic       cfg_err;
    logic       vec_valid = 1'b0;
    logic [4:0] vec_tset = '0;
    logic [2:0] vec_sym = '0;
    logic       vec_take;
    logic [1:0] cmp_res = '0;
    logic       drv_en, drv_lvl, strobe_req, res_valid, res_fail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_fmt [31], m_per [31], m_on [31], m_dat [31], m_ret [31],
        m_off [31], m_stb [31];

    always #10 clk = ~clk;

    pin_vector_formatter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_fmt(cfg_fmt), .cfg_per(cfg_per), .cfg_on(cfg_on),
        .cfg_dat(cfg_dat), .cfg_ret(cfg_ret), .cfg_off(cfg_off),
        .cfg_stb(cfg_stb), .cfg_err(cfg_err), .vec_valid(vec_valid),
        .vec_tset(vec_tset), .vec_sym(vec_sym), .vec_take(vec_take),
        .cmp_res(cmp_res), .drv_en(drv_en), .drv_lvl(drv_lvl),
        .strobe_req(strobe_req), .res_valid(res_valid), .res_fail(res_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_drive(input int sym);
        return (sym == 0) || (sym == 1);
    endfunction

    function automatic int x_en(input int ts, input int sym, input int t);
        return is_drive(sym) && (t >= m_on[ts]) && (t < m_off[ts]);
    endfunction

    function automatic int x_lvl(input int ts, input int sym, input int t);
        int d, span;
        if (!x_en(ts, sym, t)) return 0;
        d = (sym == 1);
        span = (t >= m_dat[ts]) && (t < m_ret[ts]);
        case (m_fmt[ts])
            0: return d;
            1: return span ? d : 0;
            2: return span ? d : 1;
            default: return span ? d : 1 - d;
        endcase
    endfunction

    function automatic int x_fail(input int sym, input int cmp);
        case (sym)
            2: return cmp != 0;
            3: return cmp != 1;
            5, 6: return cmp == 2;
            7: return cmp != 2;
            default: return 0;
        endcase
    endfunction

    task automatic cfg_write(input int idx, input int fmt, input int per,
                             input int on, input int dat, input int ret,
                             input int off, input int stb, input int exp_err);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_fmt = 2'(fmt);
        cfg_per = 8'(per); cfg_on = 8'(on); cfg_dat = 8'(dat);
        cfg_ret = 8'(ret); cfg_off = 8'(off); cfg_stb = 8'(stb);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(exp_err ? "R2 R10 rejected write flag" : "R2 accepted write flag",
            int'(cfg_err), exp_err);
        if (!exp_err) begin
            m_fmt[idx] = fmt; m_per[idx] = per; m_on[idx] = on; m_dat[idx] = dat;
            m_ret[idx] = ret; m_off[idx] = off; m_stb[idx] = stb;
        end
    endtask

    task automatic check_tick(input int ts, input int sym, input int cmp, input int t);
        chk("R4 drv_en", int'(drv_en), x_en(ts, sym, t));
        chk("R5 R6 R7 drv_lvl", int'(drv_lvl), x_lvl(ts, sym, t));
        chk("R8 strobe_req", int'(strobe_req), int'(!is_drive(sym) && t == m_stb[ts]));
        chk("R9 res_valid", int'(res_valid), int'(!is_drive(sym) && t == m_stb[ts] + 1));
        if (res_valid) chk("R9 res_fail", int'(res_fail), x_fail(sym, cmp));
    endtask

    // Two chained vectors, then drain to IDLE (R3, R11).
    task automatic play2(input int ts0, input int s0, input int c0,
                         input int ts1, input int s1, input int c1);
        @(negedge clk);
        cmp_res = 2'(c0); vec_valid = 1'b1; vec_tset = 5'(ts0); vec_sym = 3'(s0);
        #1 chk("R3 take from IDLE", int'(vec_take), 1);
        for (int t = 0; t < m_per[ts0]; t++) begin
            @(negedge clk);
            check_tick(ts0, s0, c0, t);
            if (t == m_per[ts0] - 1) begin
                vec_tset = 5'(ts1); vec_sym = 3'(s1); cmp_res = 2'(c1);
                #1 chk("R3 R11 chain take", int'(vec_take), 1);
            end else begin
                chk("R3 no take mid vector", int'(vec_take), 0);
            end
        end
        for (int t = 0; t < m_per[ts1]; t++) begin
            @(negedge clk);
            check_tick(ts1, s1, c1, t);
            if (t == m_per[ts1] - 1) begin
                vec_valid = 1'b0;
                #1 chk("R3 no take when idle", int'(vec_take), 0);
            end
        end
        @(negedge clk);
        chk("R3 drained drv_en", int'(drv_en), 0);
        chk("R3 drained strobe", int'(strobe_req), 0);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 31; i++) begin
            m_fmt[i] = 0; m_per[i] = 4; m_on[i] = 0; m_dat[i] = 0;
            m_ret[i] = 0; m_off[i] = 4; m_stb[i] = 1;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drv_en", int'(drv_en), 0);
        chk("R1 drv_lvl", int'(drv_lvl), 0);
        chk("R1 strobe_req", int'(strobe_req), 0);
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 idle no take", int'(vec_take), 0);
    endtask

    task automatic t_default_entry;
        // R1: untouched entries follow the default time set
        play2(9, 1, 0, 10, 7, 2);
    endtask

    task automatic t_config;
        cfg_write(0, 0, 8, 1, 2, 2, 6, 3, 0);
        cfg_write(1, 1, 8, 0, 2, 5, 8, 4, 0);
        cfg_write(2, 2, 7, 1, 2, 4, 6, 3, 0);
        cfg_write(3, 3, 10, 1, 3, 6, 9, 2, 0);
    endtask

    task automatic t_formats;
        play2(0, 1, 0, 0, 0, 0);   // R5
        play2(1, 1, 0, 1, 0, 0);   // R6 return-low
        play2(2, 0, 0, 2, 1, 0);   // R6 return-high
        play2(3, 1, 0, 3, 0, 0);   // R7
        play2(0, 1, 0, 3, 1, 0);   // R11 time set switch
        play2(2, 4, 1, 1, 1, 0);   // R4 R11 compare then drive
    endtask

    task automatic t_compare;
        for (int s = 2; s < 8; s++)
            for (int c = 0; c < 3; c++)
                play2(0, s, c, 1, s, (c + 1) % 3);   // R9
    endtask

    task automatic t_bad_cfg;
        cfg_write(6, 0, 8, 3, 2, 4, 6, 1, 1);    // R2 data before on
        play2(6, 1, 0, 6, 2, 0);                 // R12 default kept
        cfg_write(31, 0, 8, 0, 1, 2, 4, 1, 1);   // R2 index out of range
        cfg_write(7, 3, 3, 0, 1, 2, 3, 1, 1);    // R10 short SBC
        cfg_write(8, 0, 5, 0, 1, 2, 4, 5, 1);    // R2 strobe at period
        cfg_write(8, 0, 5, 0, 1, 2, 6, 1, 1);    // R2 off beyond period
        cfg_write(7, 3, 4, 0, 1, 2, 4, 1, 0);    // R10 SBC at minimum
        play2(7, 0, 0, 8, 1, 0);                 // R12 R7
    endtask

    initial begin
        t_reset();
        t_default_entry();
        t_config();
        t_formats();
        t_compare();
        t_bad_cfg();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule